// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the control state machine for a 12-bit successive-approximation converter. It moves the converter through power-up, tracking, hold and conversion, and the analog front end and the bit-decision logic follow its strobes. One start source is chosen from a group of timer outputs, an external start pin and a software start bit. Each source is synchronised to the converter clock before its edges are detected.

The chosen start can be read in two ways. In single-edge mode, one rising edge runs the whole sequence. In dual-edge mode, the rising edge opens the acquisition window and the falling edge closes it. Acquisition is longer when the amplifier gain is above unity, to give the amplifier time to settle. Two settings are refused and reported on an error flag: dual-edge mode at unity gain, and the reserved gain codes. With auto-shutdown set, the converter powers down after every conversion, so each start pays for a new power-up.

Top module: `adc_conv_sequencer`

## Requirements
- R1: `cfg_src_sel` picks the start source. Values 0 to NUM_TIMERS-1 select `timer_start[value]`, NUM_TIMERS selects `ext_start`, NUM_TIMERS+1 selects `sw_start`, and any larger value selects no source. Edges on sources that are not selected have no effect.
- R2: A rising edge on the selected source goes through a two-flop synchroniser. If the edge is accepted, `busy` and `adc_pwr_en` are high on the third clock edge after the input changes.
- R3: A start accepted while the converter is powered off holds `adc_pwr_en` high and `th_track` low for PWRUP_CYCLES cycles before tracking begins.
- R4: `cfg_gain` codes 0 to 5 mean gains 1, 2, 4, 8, 16 and 32. At code 0 the minimum track time is ACQ_MIN cycles. At codes 1 to 5 it is ACQ_MIN+PGA_SETTLE cycles.
- R5: Single-edge mode from power-off: after power-up, `th_track` stays high for exactly the minimum track time, and then the conversion starts.
- R6: Single-edge mode while powered: an accepted rising edge starts the conversion in the same cycle that `busy` rises, provided tracking has already lasted the minimum time. If it has not, the minimum time is completed first.
- R7: Dual-edge mode: the conversion starts at whichever comes later, the detected falling edge or the end of the minimum track time. This holds also when the falling edge arrives during power-up.
- R8: A conversion lasts CONV_CYCLES cycles with `th_track` low. `conv_strobe` pulses in its first cycle and `done` pulses in its last cycle.
- R9: `busy` is high from the accepted start through the `done` cycle, and is low in the cycle after `done`.
- R10: With `cfg_auto_shdn` = 0, the cycle after `done` has `adc_pwr_en` and `th_track` high. With `cfg_auto_shdn` = 1, both are low, and the next start goes through power-up again.
- R11: `cfg_err` goes high one clock after `cfg_dual_edge`=1 with `cfg_gain`=0, or after `cfg_gain` of 6 or 7. Rising edges are ignored while `cfg_err` is high.
- R12: Start edges that arrive while `busy` is high are ignored. They neither restart nor add a conversion.
- R13: During reset and right after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_src_sel | input | 3 | Start source select |
| cfg_dual_edge | input | 1 | 1 = dual-edge mode, 0 = single-edge mode |
| cfg_gain | input | 3 | Amplifier gain code |
| cfg_auto_shdn | input | 1 | Power down after each conversion |
| timer_start | input | NUM_TIMERS | Timer start outputs |
| ext_start | input | 1 | External start pin |
| sw_start | input | 1 | Software start bit |
| adc_pwr_en | output | 1 | Converter power enable |
| th_track | output | 1 | 1 = track, 0 = hold |
| conv_strobe | output | 1 | One-cycle pulse when a conversion starts |
| busy | output | 1 | A conversion sequence is in progress |
| done | output | 1 | One-cycle pulse in the last conversion cycle |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench builds the block with PWRUP_CYCLES = 5 and keeps the default 4 timers, 3-cycle minimum acquisition, 40-cycle settling and 13-cycle conversion. The short power-up lets many cold starts fit in a run, while the real settling and conversion lengths stay in place. Every one of the six sources is selected, so the non-selected and out-of-range paths are exercised. Random dual-edge falls land in both regions, before and after the minimum track time. Short idle gaps after a conversion reach the case where a powered-on start still has to finish its track time.

// File: rtl/cs_pkg.sv
// Shared types and helpers for the conversion sequencer.
// Assumes a 3-bit source select and a 3-bit gain code.
package cs_pkg;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned GAIN_W = 3;
    localparam logic [GAIN_W-1:0] GAIN_TOP_CODE = 3'd5;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PWRUP,
        ST_TRACK,
        ST_CONV,
        ST_READY
    } seq_state_t;

    // Codes above the largest gain are reserved.
    function automatic logic gain_code_ok(input logic [GAIN_W-1:0] code);
        return code <= GAIN_TOP_CODE;
    endfunction

    // Any code except 0 puts the amplifier in the path.
    function automatic logic gain_above_unity(input logic [GAIN_W-1:0] code);
        return code != '0;
    endfunction
endpackage

// File: rtl/cs_start_detect.sv
// Start-source front end: synchronises every source with two flops,
// selects one, and produces rise/fall pulses of one clock each.
// Assumes the select is changed only while the sources are low.
module cs_start_detect
    import cs_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_TIMERS-1:0] timer_start,
    input  logic                  ext_start,
    input  logic                  sw_start,
    output logic                  rise_p,
    output logic                  fall_p
);
    localparam int unsigned NUM_SRC = NUM_TIMERS + 2;
    typedef logic [SEL_W-1:0] sel_t;

    logic [NUM_SRC-1:0] src_raw;
    logic [NUM_SRC-1:0] src_meta;
    logic [NUM_SRC-1:0] src_sync;
    logic               picked;
    logic               picked_q;

    assign src_raw = {sw_start, ext_start, timer_start};

    // One two-flop synchroniser per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        // Purpose: carry source g into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_meta[g] <= 1'b0;
                src_sync[g] <= 1'b0;
            end else begin
                src_meta[g] <= src_raw[g];
                src_sync[g] <= src_meta[g];
            end
        end
    end

    // Purpose: select the synchronised source, or none when out of range.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == sel_t'(i)) picked = src_sync[i];
        end
    end

    // Purpose: remember last selected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) picked_q <= 1'b0;
        else        picked_q <= picked;
    end

    assign rise_p = picked & ~picked_q;
    assign fall_p = ~picked & picked_q;
endmodule

// File: rtl/cs_acq_counter.sv
// Acquisition timer: counts cycles spent tracking, saturating at the
// longest window, and reports when the window for the current gain is met.
// Assumes restart is given on the first tracking cycle's preceding edge.
module cs_acq_counter #(
    parameter int unsigned ACQ_MIN    = 3,
    parameter int unsigned PGA_SETTLE = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic count_en,
    input  logic gain_hi,
    output logic acq_done
);
    localparam int unsigned ACQ_LONG = ACQ_MIN + PGA_SETTLE;
    localparam int unsigned CNT_W    = $clog2(ACQ_LONG + 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(ACQ_MIN - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(ACQ_LONG - 1);

    logic [CNT_W-1:0] trk_cnt;

    // Purpose: count tracking cycles, cleared when tracking starts afresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_cnt <= '0;
        end else if (restart) begin
            trk_cnt <= '0;
        end else if (count_en && trk_cnt != LAST_LONG) begin
            trk_cnt <= trk_cnt + 1'b1;
        end
    end

    assign acq_done = trk_cnt >= (gain_hi ? LAST_LONG : LAST_SHORT);
endmodule

// File: rtl/cs_seq_fsm.sv
// Sequencing state machine: power-up, track, conversion and the
// powered-idle state. Latches the mode settings when a start is accepted.
// Assumes rise_p and fall_p are one-cycle pulses from a synchronised input.
module cs_seq_fsm
    import cs_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 8,
    parameter int unsigned CONV_CYCLES  = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_p,
    input  logic fall_p,
    input  logic cfg_dual,
    input  logic cfg_gain_hi,
    input  logic cfg_auto_shdn,
    input  logic cfg_err,
    input  logic acq_done,
    output logic gain_hi_eff,
    output logic acq_restart,
    output logic acq_count_en,
    output logic pwr_en,
    output logic th_track,
    output logic busy,
    output logic conv_strobe,
    output logic done
);
    localparam int unsigned PH_MAX = (PWRUP_CYCLES > CONV_CYCLES) ? PWRUP_CYCLES : CONV_CYCLES;
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] PWRUP_LAST = PH_W'(PWRUP_CYCLES - 1);
    localparam logic [PH_W-1:0] CONV_LAST  = PH_W'(CONV_CYCLES - 1);

    seq_state_t      state;
    seq_state_t      nxt;
    logic [PH_W-1:0] phase;
    logic            dual_q;
    logic            gain_hi_q;
    logic            shdn_q;
    logic            hold_req;
    logic            idle_state;
    logic            accept;

    assign idle_state  = (state == ST_OFF) || (state == ST_READY);
    assign accept      = idle_state && rise_p && !cfg_err;
    assign gain_hi_eff = idle_state ? cfg_gain_hi : gain_hi_q;

    // Purpose: next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (accept) nxt = ST_PWRUP;
            ST_PWRUP: if (phase == PWRUP_LAST) nxt = ST_TRACK;
            ST_TRACK: if (acq_done && (!dual_q || hold_req || fall_p)) nxt = ST_CONV;
            ST_CONV:  if (phase == CONV_LAST) nxt = shdn_q ? ST_OFF : ST_READY;
            ST_READY: if (accept) nxt = (!cfg_dual && acq_done) ? ST_CONV : ST_TRACK;
            default:  nxt = ST_OFF;
        endcase
    end

    // Purpose: state register and per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            phase <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) phase <= '0;
            else if (state == ST_PWRUP || state == ST_CONV) phase <= phase + 1'b1;
        end
    end

    // Purpose: capture mode settings at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual_q    <= 1'b0;
            gain_hi_q <= 1'b0;
            shdn_q    <= 1'b0;
        end else if (accept) begin
            dual_q    <= cfg_dual;
            gain_hi_q <= cfg_gain_hi;
            shdn_q    <= cfg_auto_shdn;
        end
    end

    // Purpose: hold a dual-edge falling edge until the track time is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_req <= 1'b0;
        end else if (accept || nxt == ST_CONV) begin
            hold_req <= 1'b0;
        end else if (fall_p && dual_q && (state == ST_PWRUP || state == ST_TRACK)) begin
            hold_req <= 1'b1;
        end
    end

    assign acq_restart  = (state == ST_PWRUP && nxt == ST_TRACK) ||
                          (state == ST_CONV  && nxt == ST_READY);
    assign acq_count_en = (state == ST_TRACK) || (state == ST_READY);

    assign pwr_en      = state != ST_OFF;
    assign th_track    = (state == ST_TRACK) || (state == ST_READY);
    assign busy        = (state == ST_PWRUP) || (state == ST_TRACK) || (state == ST_CONV);
    assign conv_strobe = (state == ST_CONV) && (phase == '0);
    assign done        = (state == ST_CONV) && (phase == CONV_LAST);
endmodule

// File: rtl/adc_conv_sequencer.sv
// Top of the conversion sequencer: configuration check, start detection,
// acquisition timing and the sequencing state machine.
// Assumes the whole block runs on the converter clock.
module adc_conv_sequencer
    import cs_pkg::*;
#(
    parameter int unsigned NUM_TIMERS   = 4,
    parameter int unsigned PWRUP_CYCLES = 8,
    parameter int unsigned ACQ_MIN      = 3,
    parameter int unsigned PGA_SETTLE   = 40,
    parameter int unsigned CONV_CYCLES  = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      cfg_src_sel,
    input  logic                  cfg_dual_edge,
    input  logic [GAIN_W-1:0]     cfg_gain,
    input  logic                  cfg_auto_shdn,
    input  logic [NUM_TIMERS-1:0] timer_start,
    input  logic                  ext_start,
    input  logic                  sw_start,
    output logic                  adc_pwr_en,
    output logic                  th_track,
    output logic                  conv_strobe,
    output logic                  busy,
    output logic                  done,
    output logic                  cfg_err
);
    logic rise_p;
    logic fall_p;
    logic acq_done;
    logic gain_hi_eff;
    logic acq_restart;
    logic acq_count_en;
    logic cfg_err_q;

    // Purpose: flag dual-edge at unity gain and reserved gain codes.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err_q <= 1'b0;
        else cfg_err_q <= (cfg_dual_edge && !gain_above_unity(cfg_gain)) ||
                          !gain_code_ok(cfg_gain);
    end

    assign cfg_err = cfg_err_q;

    cs_start_detect #(
        .NUM_TIMERS (NUM_TIMERS)
    ) u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (cfg_src_sel),
        .timer_start (timer_start),
        .ext_start   (ext_start),
        .sw_start    (sw_start),
        .rise_p      (rise_p),
        .fall_p      (fall_p)
    );

    cs_acq_counter #(
        .ACQ_MIN    (ACQ_MIN),
        .PGA_SETTLE (PGA_SETTLE)
    ) u_acq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (acq_restart),
        .count_en (acq_count_en),
        .gain_hi  (gain_hi_eff),
        .acq_done (acq_done)
    );

    cs_seq_fsm #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .CONV_CYCLES  (CONV_CYCLES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise_p        (rise_p),
        .fall_p        (fall_p),
        .cfg_dual      (cfg_dual_edge),
        .cfg_gain_hi   (gain_above_unity(cfg_gain)),
        .cfg_auto_shdn (cfg_auto_shdn),
        .cfg_err       (cfg_err_q),
        .acq_done      (acq_done),
        .gain_hi_eff   (gain_hi_eff),
        .acq_restart   (acq_restart),
        .acq_count_en  (acq_count_en),
        .pwr_en        (adc_pwr_en),
        .th_track      (th_track),
        .busy          (busy),
        .conv_strobe   (conv_strobe),
        .done          (done)
    );
endmodule

// File: rtl/cs_seq_checker.sv
// Temporal checks on the sequencer outputs; bound to the top module.
// Assumes CONV_CYCLES of at least 2.
module cs_seq_checker #(
    parameter int unsigned CONV_CYCLES = 13
) (
    input logic clk,
    input logic rst_n,
    input logic adc_pwr_en,
    input logic th_track,
    input logic conv_strobe,
    input logic busy,
    input logic done,
    input logic cfg_err
);
    localparam int unsigned AGE_W = $clog2(CONV_CYCLES + 1);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(CONV_CYCLES - 1);

    logic [AGE_W-1:0] age;

    // Purpose: cycles since the last conversion strobe, 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          age <= '0;
        else if (conv_strobe)                age <= 1;
        else if (age != '0 && age < AGE_LAST) age <= age + 1'b1;
        else                                 age <= '0;
    end

    p_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> (!th_track && busy && adc_pwr_en));
    p_done_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age == AGE_LAST));
    p_hold_in_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age != '0) |-> (!th_track && busy));
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (adc_pwr_en == th_track));
    p_err_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(cfg_err));
    p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (age != '0) |-> !conv_strobe);
    p_off_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_pwr_en |-> (!busy && !th_track));
endmodule

bind adc_conv_sequencer cs_seq_checker #(
    .CONV_CYCLES (CONV_CYCLES)
) u_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_pwr_en  (adc_pwr_en),
    .th_track    (th_track),
    .conv_strobe (conv_strobe),
    .busy        (busy),
    .done        (done),
    .cfg_err     (cfg_err)
);

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;
    localparam int NT = 4, PW = 5, AMIN = 3, SETTLE = 40, CONV = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_src_sel = '0;
    logic          cfg_dual_edge = 1'b0;
    logic [2:0]    cfg_gain = '0;
    logic          cfg_auto_shdn = 1'b0;
    logic [NT-1:0] timer_start = '0;
    logic          ext_start = 1'b0;
    logic          sw_start = 1'b0;
    logic adc_pwr_en, th_track, conv_strobe, busy, done, cfg_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  powered = 1'b0;
    int  extra_gap = 0;
    bit  finished = 1'b0;

    adc_conv_sequencer #(
        .NUM_TIMERS(NT), .PWRUP_CYCLES(PW), .ACQ_MIN(AMIN),
        .PGA_SETTLE(SETTLE), .CONV_CYCLES(CONV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_src_sel(cfg_src_sel),
        .cfg_dual_edge(cfg_dual_edge), .cfg_gain(cfg_gain),
        .cfg_auto_shdn(cfg_auto_shdn), .timer_start(timer_start),
        .ext_start(ext_start), .sw_start(sw_start), .adc_pwr_en(adc_pwr_en),
        .th_track(th_track), .conv_strobe(conv_strobe), .busy(busy),
        .done(done), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_acq(input int g);
        return (g == 0) ? AMIN : AMIN + SETTLE;
    endfunction

    // Cycles from busy rising to the conversion strobe.
    function automatic int exp_lat(input bit cold, input bit dual, input int d,
                                   input int g, input int gap);
        int base;
        if (cold) base = PW + exp_acq(g);
        else      base = (exp_acq(g) - gap - 3 > 0) ? exp_acq(g) - gap - 3 : 0;
        if (!dual) return base;
        return (d > base) ? d : base;
    endfunction

    task automatic drive_src(input int sel, input logic v);
        if (sel < NT)           timer_start[sel] = v;
        else if (sel == NT)     ext_start = v;
        else if (sel == NT + 1) sw_start = v;
    endtask

    task automatic run_conv(input int sel, input bit dual, input int gain,
                            input bit shdn, input int d, input int idle,
                            input bit glitch);
        int  t_busy, t_s, t_d, pwr_cnt, trk_cnt, gap, lat;
        bit  trk_seen, cold;
        string tag;
        repeat (idle) @(negedge clk);
        cfg_src_sel = 3'(sel); cfg_dual_edge = dual;
        cfg_gain = 3'(gain); cfg_auto_shdn = shdn;
        repeat (3) @(negedge clk);
        gap  = extra_gap + idle + 3;
        cold = !powered;
        drive_src(sel, 1'b1);
        t_busy = -1; t_s = -1; t_d = -1; pwr_cnt = 0; trk_cnt = 0; trk_seen = 0;
        for (int t = 1; t < 400 && t_d < 0; t++) begin
            @(negedge clk);
            if (busy && t_busy < 0) t_busy = t;
            if (t_s < 0 && busy && th_track) begin trk_seen = 1; trk_cnt++; end
            if (t_s < 0 && busy && !th_track && !trk_seen && !conv_strobe) pwr_cnt++;
            if (conv_strobe && t_s < 0) begin
                t_s = t;
                check(!th_track, "R8", "track at strobe", int'(th_track), 0);
            end
            if (done) t_d = t;
            if (dual && t == d) drive_src(sel, 1'b0);
            if (!dual && t == 4) drive_src(sel, 1'b0);
            if (glitch && t_s > 0 && t == t_s + 4) drive_src(sel, 1'b1);
            if (glitch && t_s > 0 && t == t_s + 6) drive_src(sel, 1'b0);
        end
        check(t_busy == 3, "R2", "busy latency", t_busy, 3);
        if (cold) check(pwr_cnt == PW, "R3", "power-up cycles", pwr_cnt, PW);
        if (cold && !dual) check(trk_cnt == exp_acq(gain), "R4", "track cycles",
                                 trk_cnt, exp_acq(gain));
        lat = exp_lat(cold, dual, d, gain, gap);
        tag = dual ? "R7" : (cold ? "R5" : "R6");
        check(t_s - t_busy == lat, tag, "busy-to-strobe", t_s - t_busy, lat);
        check(t_d - t_s == CONV - 1, "R8", "strobe-to-done", t_d - t_s, CONV - 1);
        @(negedge clk);
        check(!busy, "R9", "busy after done", int'(busy), 0);
        check(adc_pwr_en == !shdn && th_track == !shdn, "R10", "power/track after done",
              int'({adc_pwr_en, th_track}), shdn ? 0 : 3);
        powered = !shdn;
        extra_gap = 0;
        if (glitch) begin
            int seen = 0;
            repeat (20) begin @(negedge clk); if (busy) seen++; end
            check(seen == 0, "R12", "busy cycles after ignored edges", seen, 0);
            extra_gap = 20;
        end
    endtask

    task automatic expect_idle(input string req, input string what, input int n);
        int seen = 0;
        repeat (n) begin @(negedge clk); if (busy || adc_pwr_en != powered) seen++; end
        check(seen == 0, req, what, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog: got %0d cycles expected fewer", 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check({adc_pwr_en, th_track, conv_strobe, busy, done, cfg_err} == 6'b0,
              "R13", "outputs in reset",
              int'({adc_pwr_en, th_track, conv_strobe, busy, done, cfg_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({adc_pwr_en, th_track, conv_strobe, busy, done, cfg_err} == 6'b0,
              "R13", "outputs after reset",
              int'({adc_pwr_en, th_track, conv_strobe, busy, done, cfg_err}), 0);

        // R11: illegal settings raise the flag and block starts.
        cfg_src_sel = 3'd4; cfg_dual_edge = 1'b1; cfg_gain = 3'd0;
        repeat (2) @(negedge clk);
        check(cfg_err, "R11", "dual at unity gain", int'(cfg_err), 1);
        ext_start = 1'b1; expect_idle("R11", "start while error", 8); ext_start = 1'b0;
        cfg_dual_edge = 1'b0; cfg_gain = 3'd6;
        repeat (2) @(negedge clk);
        check(cfg_err, "R11", "reserved gain", int'(cfg_err), 1);
        cfg_gain = 3'd2;
        repeat (2) @(negedge clk);
        check(!cfg_err, "R11", "legal setting clears flag", int'(cfg_err), 0);

        // R1: sources not selected, and out-of-range select, do nothing.
        cfg_src_sel = 3'd1;
        timer_start[2] = 1'b1; ext_start = 1'b1; sw_start = 1'b1;
        expect_idle("R1", "unselected sources", 8);
        timer_start = '0; ext_start = 1'b0; sw_start = 1'b0;
        repeat (4) @(negedge clk);
        cfg_src_sel = 3'd6;
        timer_start = '1; ext_start = 1'b1; sw_start = 1'b1;
        expect_idle("R1", "no source selected", 8);
        timer_start = '0; ext_start = 1'b0; sw_start = 1'b0;
        repeat (4) @(negedge clk);

        // Directed sequences.
        run_conv(0, 0, 0, 1, 0, 0, 0);   // cold single, unity gain, shutdown
        run_conv(5, 0, 3, 0, 0, 5, 0);   // cold single, gain 8, stays powered
        run_conv(4, 0, 0, 0, 0, 0, 0);   // warm single, short gap, unity
        run_conv(1, 0, 2, 0, 0, 0, 0);   // warm single, short gap, must finish track
        run_conv(2, 1, 1, 0, 10, 60, 0); // warm dual
        run_conv(3, 0, 0, 1, 0, 60, 1);  // edges during conversion
        run_conv(4, 1, 5, 0, 2, 10, 0);  // cold dual, fall during power-up
        run_conv(5, 1, 1, 1, 7, 60, 0);  // warm dual, then shut down
        run_conv(0, 1, 4, 1, 60, 10, 0); // cold dual, late fall

        // Random sequences.
        for (int k = 0; k < 40; k++) begin
            int sel, gain, d, idle;
            bit dual, shdn, gl;
            sel  = int'($urandom_range(0, 5));
            gain = int'($urandom_range(0, 5));
            dual = (gain != 0) && ($urandom_range(0, 1) == 1);
            shdn = ($urandom_range(0, 2) == 0);
            d    = int'($urandom_range(1, 60));
            idle = int'($urandom_range(0, 50));
            gl   = ($urandom_range(0, 3) == 0);
            run_conv(sel, dual, gain, shdn, d, idle, gl);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule